// File: doc/BRIEF.md
# Common-Mode Interference Canceller Coefficient Integrator

This block keeps the two weighting coefficients, in-phase (I) and quadrature (Q), that a common-mode interference canceller uses to subtract pickup from a received line signal. Each coefficient is a saturating up/down counter. The counter integrates a one-bit sign from a correlator. A 1 from the correlator means the weight is too small and the counter steps up. A 0 means the weight is too large and the counter steps down.

Adaptation is allowed only inside a short window that recurs once per superframe. The default timing is a 552-cycle window at the end of an 11040-cycle frame. At all other times the coefficients are frozen. Software selects how aggressively the loop adapts by choosing which 8-bit slice of each 12-bit counter drives the canceller. Software can also reverse the loop sign. For test, software can replace the correlator signs with a forced direction, and it can load either counter directly.

Top module: `rfi_coef_integrator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, both counters read 0, both coefficients read 0 and `adapt_win` is 0.
- R2: While the window is open, each counter moves by exactly one per clock. The counter rises when its direction is 1 and falls when its direction is 0. With no test controls set, the direction is the correlator sign.
- R3: A counter at 4095 that is told to rise stays at 4095. A counter at 0 that is told to fall stays at 0. Neither counter ever wraps.
- R4: `cfg_step` selects the 8-bit coefficient slice of the counter: 0 selects bits 11:4, 1 selects bits 10:3, 2 selects bits 9:2 and 3 selects bits 8:1. The coefficient follows `cfg_step` in the same cycle.
- R5: When `cfg_invert` is 1, each counter's direction is the complement of its selected source. This applies to both the correlator sign and the forced bit.
- R6: When `cfg_force_sel` is 1, both counters take their direction from `cfg_force_up` (1 = up, 0 = down), and the correlator signs have no effect.
- R7: When `cfg_online` is 0, no counting happens and `adapt_win` stays 0. The counters change only through writes.
- R8: A phase counter runs from 0 after reset and wraps at `FRAME_CYCLES`. `adapt_win` is 1 exactly when `cfg_online` is 1 and the phase lies in [`WIN_START`, `WIN_START+WIN_LEN`). Counting happens only on those cycles, and the coefficients hold at all other times.
- R9: A write strobe loads `wr_data` into its counter on the next clock. The write wins over counting in that cycle, and `cnt_i`/`cnt_q` read the loaded value back.
- R10: The I and Q counters are independent. Each one uses only its own correlator sign and its own write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_online | input | 1 | Canceller enable; 0 freezes adaptation |
| cfg_step | input | 2 | Adaptation-rate slice select |
| cfg_invert | input | 1 | Reverse the direction of both counters |
| cfg_force_sel | input | 1 | 1 = direction from cfg_force_up instead of the correlators |
| cfg_force_up | input | 1 | Forced direction, 1 = up |
| corr_i | input | 1 | I correlator sign, 1 = up |
| corr_q | input | 1 | Q correlator sign, 1 = up |
| wr_i_en | input | 1 | Load the I counter from wr_data |
| wr_q_en | input | 1 | Load the Q counter from wr_data |
| wr_data | input | 12 | Counter load value |
| cnt_i | output | 12 | I counter readback |
| cnt_q | output | 12 | Q counter readback |
| coef_i | output | 8 | I weighting coefficient slice |
| coef_q | output | 8 | Q weighting coefficient slice |
| adapt_win | output | 1 | Adaptation window currently open |

## Verification
The integrator is driven under several input patterns, and each one separates a different fault:
- Constant-up correlator signs over several frames show whether counting happens only in the window and at exactly one step per clock.
- Opposite I and Q signs show whether the channels are swapped or coupled.
- Random signs with inversion, and forced directions that oppose the random signs, show which direction source is actually in use.
- Loads near 4095 and 0 followed by counting toward the rail show saturation as opposed to wrapping.
- Sweeping all four step values over a fixed load shows the slice positions.
- Writes issued inside an open window show that a write takes priority over a count.

// File: rtl/rfi_coef_pkg.sv
package rfi_coef_pkg;

    localparam int unsigned CNT_W_DEF = 12;
    localparam int unsigned OUT_W_DEF = 8;
    localparam int unsigned NCH       = 2;

    typedef enum logic [1:0] {
        STEP_SLOWEST = 2'b00,
        STEP_SLOW    = 2'b01,
        STEP_FAST    = 2'b10,
        STEP_FASTEST = 2'b11
    } step_e;

    typedef struct packed {
        logic load;
        logic adapt;
        logic up;
    } cnt_ctl_t;

    function automatic logic pick_dir(input logic corr, input logic fsel,
                                      input logic fup, input logic inv);
        return (fsel ? fup : corr) ^ inv;
    endfunction

endpackage

// File: rtl/rfi_window_timer.sv
module rfi_window_timer #(
    parameter int unsigned FRAME_CYCLES = 11040,
    parameter int unsigned WIN_START    = 10488,
    parameter int unsigned WIN_LEN      = 552
) (
    input  logic clk,
    input  logic rst,
    output logic win_open
);
    localparam int unsigned PH_W    = $clog2(FRAME_CYCLES);
    localparam int unsigned WIN_END = WIN_START + WIN_LEN;

    logic [PH_W-1:0] phase;
    logic [31:0]     ph32;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (32'(phase) == FRAME_CYCLES - 1)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        ph32     = 32'(phase);
        win_open = (ph32 >= WIN_START) && (ph32 < WIN_END);
    end

endmodule

// File: rtl/rfi_sat_counter.sv
module rfi_sat_counter
    import rfi_coef_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ctl.load)
            cnt <= load_val;
        else if (ctl.adapt) begin
            if (ctl.up && cnt != TOP)
                cnt <= cnt + 1'b1;
            else if (!ctl.up && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/rfi_slice_sel.sv
module rfi_slice_sel #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned OUT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       step,
    output logic [OUT_W-1:0] coef
);
    localparam int unsigned SH_MAX = CNT_W - OUT_W;

    logic [CNT_W-1:0] shifted;

    always_comb begin
        shifted = cnt >> (SH_MAX - 32'(step));
        coef    = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/rfi_coef_integrator.sv
module rfi_coef_integrator
    import rfi_coef_pkg::*;
#(
    parameter int unsigned CNT_W        = CNT_W_DEF,
    parameter int unsigned OUT_W        = OUT_W_DEF,
    parameter int unsigned FRAME_CYCLES = 11040,
    parameter int unsigned WIN_START    = 10488,
    parameter int unsigned WIN_LEN      = 552
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_online,
    input  logic [1:0]       cfg_step,
    input  logic             cfg_invert,
    input  logic             cfg_force_sel,
    input  logic             cfg_force_up,
    input  logic             corr_i,
    input  logic             corr_q,
    input  logic             wr_i_en,
    input  logic             wr_q_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [OUT_W-1:0] coef_i,
    output logic [OUT_W-1:0] coef_q,
    output logic             adapt_win
);
    logic             win_open;
    logic [NCH-1:0]   corr_v;
    logic [NCH-1:0]   wr_v;
    cnt_ctl_t         ctl   [NCH];
    logic [CNT_W-1:0] cnt_v [NCH];
    logic [OUT_W-1:0] coef_v[NCH];

    rfi_window_timer #(
        .FRAME_CYCLES(FRAME_CYCLES),
        .WIN_START   (WIN_START),
        .WIN_LEN     (WIN_LEN)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_open(win_open)
    );

    assign adapt_win = win_open & cfg_online;
    assign corr_v    = {corr_q, corr_i};
    assign wr_v      = {wr_q_en, wr_i_en};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            ctl[ch].load  = wr_v[ch];
            ctl[ch].adapt = adapt_win;
            ctl[ch].up    = pick_dir(corr_v[ch], cfg_force_sel, cfg_force_up, cfg_invert);
        end

        rfi_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[ch]),
            .load_val(wr_data),
            .cnt     (cnt_v[ch])
        );

        rfi_slice_sel #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_slice (
            .cnt (cnt_v[ch]),
            .step(cfg_step),
            .coef(coef_v[ch])
        );
    end

    assign cnt_i  = cnt_v[0];
    assign cnt_q  = cnt_v[1];
    assign coef_i = coef_v[0];
    assign coef_q = coef_v[1];

endmodule

// File: rtl/rfi_coef_checker.sv
module rfi_coef_checker #(
    parameter int unsigned CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_online,
    input logic             wr_i_en,
    input logic             wr_q_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] cnt_q,
    input logic             adapt_win
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R9
    load_i_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i_en |=> cnt_i == $past(wr_data));
    // R9
    load_q_chk: assert property (@(posedge clk) disable iff (rst)
        wr_q_en |=> cnt_q == $past(wr_data));
    // R2
    unit_step_i_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i_en |=> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1
                      || cnt_i == $past(cnt_i) - 1'b1));
    // R3
    no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_i == TOP && !wr_i_en) |=> cnt_i != '0);
    // R3
    no_wrap_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !wr_q_en) |=> cnt_q != TOP);
    // R8
    hold_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!adapt_win && !wr_i_en && !wr_q_en) |=> ($stable(cnt_i) && $stable(cnt_q)));
    // R7
    offline_closed_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_online |-> !adapt_win);

endmodule

bind rfi_coef_integrator rfi_coef_checker #(.CNT_W(CNT_W)) u_coef_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_online(cfg_online),
    .wr_i_en   (wr_i_en),
    .wr_q_en   (wr_q_en),
    .wr_data   (wr_data),
    .cnt_i     (cnt_i),
    .cnt_q     (cnt_q),
    .adapt_win (adapt_win)
);

// File: tb/rfi_coef_integrator_bench.sv
module rfi_coef_integrator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12, OW = 8, FRAME = 32, WS = 8, WL = 12;
    localparam int TOPV = 4095;

    logic clk = 0, rst = 1;
    logic cfg_online = 0, cfg_invert = 0, cfg_force_sel = 0, cfg_force_up = 0;
    logic [1:0] cfg_step = 0;
    logic corr_i = 0, corr_q = 0, wr_i_en = 0, wr_q_en = 0;
    logic [CW-1:0] wr_data = 0;
    logic [CW-1:0] cnt_i, cnt_q;
    logic [OW-1:0] coef_i, coef_q;
    logic adapt_win;

    rfi_coef_integrator #(.CNT_W(CW), .OUT_W(OW), .FRAME_CYCLES(FRAME),
                          .WIN_START(WS), .WIN_LEN(WL)) u_rfi_coef_integrator (
        .clk(clk), .rst(rst), .cfg_online(cfg_online), .cfg_step(cfg_step),
        .cfg_invert(cfg_invert), .cfg_force_sel(cfg_force_sel),
        .cfg_force_up(cfg_force_up), .corr_i(corr_i), .corr_q(corr_q),
        .wr_i_en(wr_i_en), .wr_q_en(wr_q_en), .wr_data(wr_data),
        .cnt_i(cnt_i), .cnt_q(cnt_q), .coef_i(coef_i), .coef_q(coef_q),
        .adapt_win(adapt_win));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int m_phase = 0, m_i = 0, m_q = 0;
    string cur_tag = "R1";
    bit checking = 0;
    int step_hist[$];

    function automatic bit model_win();
        return cfg_online && m_phase >= WS && m_phase < WS + WL;
    endfunction

    function automatic int step_cnt(int v, bit up);
        if (up) return (v < TOPV) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    function automatic int slice(int v, int s);
        return (v >> (CW - OW - s)) & ((1 << OW) - 1);
    endfunction

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_i = 0; m_q = 0;
        end else begin
            bit w;
            bit di, dq;
            w  = model_win();
            di = (cfg_force_sel ? cfg_force_up : corr_i) ^ cfg_invert;
            dq = (cfg_force_sel ? cfg_force_up : corr_q) ^ cfg_invert;
            if (wr_i_en) m_i = wr_data; else if (w) m_i = step_cnt(m_i, di);
            if (wr_q_en) m_q = wr_data; else if (w) m_q = step_cnt(m_q, dq);
            m_phase = (m_phase + 1) % FRAME;
        end
    end

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // compared on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            cmp({cur_tag, " cnt_i"}, int'(cnt_i), m_i);
            cmp({cur_tag, " cnt_q"}, int'(cnt_q), m_q);
            cmp("R4 coef_i", int'(coef_i), slice(m_i, int'(cfg_step)));
            cmp("R4 coef_q", int'(coef_q), slice(m_q, int'(cfg_step)));
            cmp("R8 adapt_win", int'(adapt_win), int'(model_win()));
            step_hist.push_back(int'(cfg_step));
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic write(bit to_i, bit to_q, int val);
        wr_data = CW'(val); wr_i_en = to_i; wr_q_en = to_q;
        tick();
        wr_i_en = 0; wr_q_en = 0;
    endtask

    bit finished = 0;

    initial begin
        tick(3);
        // R1: reset values while in reset
        cmp("R1 cnt_i", int'(cnt_i), 0);
        cmp("R1 coef_q", int'(coef_q), 0);
        cmp("R1 adapt_win", int'(adapt_win), 0);
        rst = 0;
        checking = 1;
        cur_tag = "R1";
        tick();

        // R2 / R8: constant up for two frames
        cur_tag = "R2";
        cfg_online = 1; corr_i = 1; corr_q = 1;
        tick(2 * FRAME);
        cur_tag = "R8";
        tick(FRAME / 2);

        // R10: opposite signs, Q preloaded (R9 load)
        cur_tag = "R10";
        write(0, 1, 100);
        corr_i = 1; corr_q = 0;
        tick(FRAME);

        // R5: inversion with random signs
        cur_tag = "R5";
        cfg_invert = 1;
        for (int k = 0; k < 2 * FRAME; k++) begin
            corr_i = 1'($urandom); corr_q = 1'($urandom); tick();
        end
        cfg_invert = 0;

        // R6: forced direction against random signs
        cur_tag = "R6";
        cfg_force_sel = 1;
        cfg_force_up = 0;
        for (int k = 0; k < FRAME; k++) begin
            corr_i = 1'($urandom); corr_q = 1'($urandom); tick();
        end
        cfg_force_up = 1;
        for (int k = 0; k < FRAME; k++) begin
            corr_i = 1'($urandom); corr_q = 1'($urandom); tick();
        end
        cfg_invert = 1;
        tick(FRAME);
        cfg_invert = 0; cfg_force_sel = 0;

        // R7: offline, counters frozen
        cur_tag = "R7";
        cfg_online = 0;
        for (int k = 0; k < 2 * FRAME; k++) begin
            corr_i = 1'($urandom); corr_q = 1'($urandom); tick();
        end

        // R3: saturation at both rails
        cur_tag = "R3";
        write(1, 0, TOPV - 3);
        write(0, 1, 4);
        cfg_online = 1; corr_i = 1; corr_q = 0;
        tick(FRAME + 4);
        cmp("R3 top rail", int'(cnt_i), TOPV);
        cmp("R3 zero rail", int'(cnt_q), 0);

        // R4: sweep slices on a fixed pattern
        cur_tag = "R4";
        cfg_online = 0;
        write(1, 1, 12'hABC);
        for (int s = 0; s < 4; s++) begin
            cfg_step = 2'(s); tick(3);
        end
        cfg_step = 2'(0);

        // R9: writes inside an open window take priority
        cur_tag = "R9";
        cfg_online = 1; corr_i = 1; corr_q = 1;
        while (!adapt_win) tick();
        write(1, 0, 2000);
        write(0, 1, 77);
        write(1, 1, 5);
        tick(FRAME);

        checking = 0;
        if (step_hist.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R4 no per-cycle samples taken: actual 0 expected >0");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule